// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer takes one load request from a 32-lane warp. The request holds one byte address per lane, a mask that marks which lanes are active, and an element size that applies to every lane. It turns that request into the fewest naturally aligned memory transactions that together cover every byte any active lane touches. Each transaction is 32, 64 or 128 bytes. It carries its aligned base address, a size code, and the mask of lanes whose bytes fall inside it.

Transactions leave one per cycle on a registered valid/ready port, in ascending address order. The final transaction of a request is flagged. A lane may start at an address that is not aligned to its element size. Such a lane can straddle a 32-byte sector, and it can also straddle a 128-byte segment. In the second case the lane shows up in two transactions. The request port stays closed from acceptance until the last transaction of that request has been taken. Returning data to the lanes is handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: After a request with at least one active lane is accepted, `in_ready` stays low until the transaction flagged last has been taken. `in_ready` is high again on the following cycle, and it is high after reset.
- R2: Lane i covers bytes `addr_i` through `addr_i + 2^in_esz - 1`, with `in_esz` code 0/1/2/3 meaning 1/2/4/8 bytes. A lane that crosses into the next 128-byte segment is listed in the transactions of both segments.
- R3: Exactly one transaction is emitted for each distinct aligned 128-byte segment that the active lanes touch. No transaction is ever split further. A warp whose 32 lanes each hit a different segment therefore produces 32 transactions.
- R4: `tx_size` code 0 means 32 bytes, 1 means 64 bytes and 2 means 128 bytes. Code 0 is used when the touched bytes of a segment lie in one 32-byte quarter. Code 1 is used when they lie in one aligned 64-byte half. Otherwise code 2 is used, even when the touched quarters are not adjacent.
- R5: `tx_base` is aligned to the transaction size, and its range contains every byte that the listed lanes touch in that segment.
- R6: `tx_lanes` has bit i set exactly when active lane i touches the transaction's segment. Inactive lanes never appear in any transaction.
- R7: Within a request, transactions leave in strictly ascending base-address order, regardless of lane order.
- R8: `tx_last` is high on the final transaction of a request and low on every other one.
- R9: While `tx_valid` is high and `tx_ready` is low, every `tx_*` output holds its value.
- R10: A request with no active lane is accepted and produces no transaction.
- R11: 32 active lanes reading consecutive 4-byte elements from a 128-byte-aligned base produce a single 128-byte transaction that lists all 32 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | LANES*AW | Lane byte addresses, lane i at bits [i*AW +: AW] |
| in_mask | input | LANES | Active-lane mask |
| in_esz | input | 2 | Element size code, 1 << code bytes |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Consumer takes the transaction |
| tx_base | output | AW | Aligned base byte address |
| tx_size | output | 2 | 0 = 32 B, 1 = 64 B, 2 = 128 B |
| tx_lanes | output | LANES | Lanes served by this transaction |
| tx_last | output | 1 | Final transaction of the request |

## Verification
The bench targets several corner cases:
- Lanes whose addresses are reversed relative to lane order. A design that followed lane order instead of address order would emit descending bases.
- Two far quarters of one segment. A design that minimised bytes rather than transactions would split these into two 32-byte accesses.
- Unaligned 8-byte elements straddling a segment edge. A design that ignored the element size would drop the second transaction.
- Masked-off lanes parked in their own segments, and an all-zero mask. These would surface as extra transactions or a hung port if the mask were not honoured.
- Random consumer back-pressure. This exposes output fields that change while stalled, and a request port that reopens before the last transaction is taken.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;
  localparam int SECT_SHIFT = 5;   // 32-byte sector
  localparam int SEG_SHIFT  = 7;   // 128-byte segment

  typedef enum logic [1:0] {
    TX_32B  = 2'd0,
    TX_64B  = 2'd1,
    TX_128B = 2'd2
  } tx_size_e;
endpackage

// File: rtl/wcoal_lane_span.sv
// First and last 32-byte sector touched by one lane's element.
module wcoal_lane_span
  import wcoal_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]            addr,
  input  logic [1:0]               esz,
  output logic [AW-SECT_SHIFT-1:0] first_sec,
  output logic [AW-SECT_SHIFT-1:0] last_sec
);
  localparam int SA = AW - SECT_SHIFT;

  logic carry;

  always_comb begin
    carry     = ({1'b0, addr[SECT_SHIFT-1:0]} + ((6'd1 << esz) - 6'd1)) > 6'd31;
    first_sec = addr[AW-1:SECT_SHIFT];
    last_sec  = first_sec + {{(SA-1){1'b0}}, carry};
  end
endmodule

// File: rtl/wcoal_min_seg.sv
// Lowest 128-byte segment among lanes that still owe a transaction.
module wcoal_min_seg #(
  parameter int LANES = 32,
  parameter int SW    = 25
) (
  input  logic [LANES*SW-1:0] seg,
  input  logic [LANES-1:0]    act,
  output logic [SW-1:0]       min_seg
);
  logic found;

  always_comb begin
    min_seg = '1;
    found   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (act[i] && (!found || seg[i*SW +: SW] < min_seg)) begin
        min_seg = seg[i*SW +: SW];
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wcoal_shape.sv
// Lanes served in the chosen segment and the smallest aligned window covering them.
module wcoal_shape
  import wcoal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*(AW-SECT_SHIFT)-1:0] cur_sec,
  input  logic [LANES*(AW-SECT_SHIFT)-1:0] end_sec,
  input  logic [LANES-1:0]                 act,
  input  logic [LANES-1:0]                 pend_lo,
  input  logic [AW-SEG_SHIFT-1:0]          min_seg,
  output logic [LANES-1:0]                 served,
  output logic [LANES-1:0]                 hi_clear,
  output logic [AW-1:0]                    base,
  output tx_size_e                         size
);
  localparam int SA = AW - SECT_SHIFT;

  logic [3:0] touched;
  logic       single;
  logic [1:0] sec_idx;

  always_comb begin
    logic [SA-1:0] cs;
    logic [SA-1:0] es;
    served   = '0;
    hi_clear = '0;
    touched  = '0;
    for (int i = 0; i < LANES; i++) begin
      cs = cur_sec[i*SA +: SA];
      es = end_sec[i*SA +: SA];
      if (act[i] && cs[SA-1:2] == min_seg) begin
        served[i]         = 1'b1;
        touched[cs[1:0]]  = 1'b1;
        if (!pend_lo[i]) begin
          hi_clear[i] = 1'b1;
        end else if (es[SA-1:2] == min_seg) begin
          hi_clear[i]      = 1'b1;
          touched[es[1:0]] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    single = (touched != 4'd0) && ((touched & (touched - 4'd1)) == 4'd0);
    case (touched)
      4'b0010: sec_idx = 2'd1;
      4'b0100: sec_idx = 2'd2;
      4'b1000: sec_idx = 2'd3;
      default: sec_idx = 2'd0;
    endcase
    if (single) begin
      size = TX_32B;
      base = {min_seg, sec_idx, 5'b0};
    end else if (touched[3:2] == 2'b00) begin
      size = TX_64B;
      base = {min_seg, 1'b0, 6'b0};
    end else if (touched[1:0] == 2'b00) begin
      size = TX_64B;
      base = {min_seg, 1'b1, 6'b0};
    end else begin
      size = TX_128B;
      base = {min_seg, 7'b0};
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import wcoal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*AW-1:0]   in_addr,
  input  logic [LANES-1:0]      in_mask,
  input  logic [1:0]            in_esz,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [AW-1:0]         tx_base,
  output logic [1:0]            tx_size,
  output logic [LANES-1:0]      tx_lanes,
  output logic                  tx_last
);
  localparam int SA = AW - SECT_SHIFT;
  localparam int SW = AW - SEG_SHIFT;

  // captured lane footprints, sector granular
  logic [LANES*SA-1:0] st_d, en_d, st_q, en_q;
  logic [LANES*SA-1:0] cur_flat;
  logic [LANES*SW-1:0] seg_flat;
  logic [LANES-1:0]    cross_d;

  logic [LANES-1:0] pend_lo_q, pend_hi_q, act, req_mask_q;
  logic [LANES-1:0] served, hi_clear, lo_next, hi_next;
  logic [SW-1:0]    min_seg;
  logic [AW-1:0]    sh_base;
  tx_size_e         sh_size;
  logic             accept, load;

  logic [AW-1:0]    prev_base_q;
  logic             have_prev_q;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      wcoal_lane_span #(.AW(AW)) u_span (
        .addr      (in_addr[g*AW +: AW]),
        .esz       (in_esz),
        .first_sec (st_d[g*SA +: SA]),
        .last_sec  (en_d[g*SA +: SA])
      );
      assign cross_d[g]             = st_d[g*SA +: SA] != en_d[g*SA +: SA];
      assign cur_flat[g*SA +: SA]   = pend_lo_q[g] ? st_q[g*SA +: SA] : en_q[g*SA +: SA];
      assign seg_flat[g*SW +: SW]   = cur_flat[g*SA + 2 +: SW];
    end
  endgenerate

  assign act = pend_lo_q | pend_hi_q;

  wcoal_min_seg #(.LANES(LANES), .SW(SW)) u_min (
    .seg     (seg_flat),
    .act     (act),
    .min_seg (min_seg)
  );

  wcoal_shape #(.LANES(LANES), .AW(AW)) u_shape (
    .cur_sec  (cur_flat),
    .end_sec  (en_q),
    .act      (act),
    .pend_lo  (pend_lo_q),
    .min_seg  (min_seg),
    .served   (served),
    .hi_clear (hi_clear),
    .base     (sh_base),
    .size     (sh_size)
  );

  assign lo_next  = pend_lo_q & ~served;
  assign hi_next  = pend_hi_q & ~hi_clear;
  assign in_ready = !tx_valid && (act == '0);
  assign accept   = in_valid && in_ready;
  assign load     = (act != '0) && (!tx_valid || tx_ready);

  always_ff @(posedge clk) begin
    if (accept) begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lo_q  <= '0;
      pend_hi_q  <= '0;
      req_mask_q <= '0;
      tx_valid   <= 1'b0;
      tx_base    <= '0;
      tx_size    <= '0;
      tx_lanes   <= '0;
      tx_last    <= 1'b0;
    end else if (accept) begin
      pend_lo_q  <= in_mask;
      pend_hi_q  <= in_mask & cross_d;
      req_mask_q <= in_mask;
    end else if (load) begin
      pend_lo_q <= lo_next;
      pend_hi_q <= hi_next;
      tx_valid  <= 1'b1;
      tx_base   <= sh_base;
      tx_size   <= sh_size;
      tx_lanes  <= served;
      tx_last   <= (lo_next | hi_next) == '0;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // order tracking for the ascending-address check
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_base_q <= '0;
      have_prev_q <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      prev_base_q <= tx_base;
      have_prev_q <= !tx_last;
    end
  end

  a_r1_closed_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mask != '0) |=> !in_ready);

  a_r4_size_legal: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_size != 2'd3);

  a_r5_base_aligned: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_size == 2'd0 && tx_base[4:0] == 5'd0) ||
                  (tx_size == 2'd1 && tx_base[5:0] == 6'd0) ||
                  (tx_size == 2'd2 && tx_base[6:0] == 7'd0)));

  a_r6_lanes_from_mask: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_lanes != '0 && (tx_lanes & ~req_mask_q) == '0));

  a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && have_prev_q) |-> tx_base > prev_base_q);

  a_r8_last_reopens: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> in_ready);

  a_r8_not_last_stays_closed: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_last) |=> !in_ready);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_size) &&
                                 $stable(tx_lanes) && $stable(tx_last)));
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int SA    = AW - 5;
  localparam int SW    = AW - 7;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0]   in_mask = '0;
  logic [1:0]         in_esz = '0;
  logic               tx_valid;
  logic               tx_ready = 1'b0;
  logic [AW-1:0]      tx_base;
  logic [1:0]         tx_size;
  logic [LANES-1:0]   tx_lanes;
  logic               tx_last;

  warp_coalescer #(.LANES(LANES), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .in_esz(in_esz),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base),
    .tx_size(tx_size), .tx_lanes(tx_lanes), .tx_last(tx_last)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // stimulus
  logic [AW-1:0]    a [LANES];
  logic [LANES-1:0] m;
  logic [1:0]       esz;

  // expected transactions
  logic [AW-1:0]    e_base  [64];
  logic [1:0]       e_size  [64];
  logic [LANES-1:0] e_lanes [64];
  int               e_n;

  // observed summary of last run
  int               obs_n;
  logic [AW-1:0]    obs_base0;
  logic [1:0]       obs_size0;
  logic [LANES-1:0] obs_lanes0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void build_expected();
    logic [SA-1:0] s0 [LANES];
    logic [SA-1:0] s1 [LANES];
    logic [AW-1:0] tail;
    logic [SW-1:0] best, prev, sg;
    logic [3:0]    t;
    logic [LANES-1:0] ln;
    bit have, found;
    int cnt, idx;
    for (int i = 0; i < LANES; i++) begin
      s0[i] = a[i][AW-1:5];
      tail  = a[i] + ((32'd1 << esz) - 32'd1);
      s1[i] = tail[AW-1:5];
    end
    e_n = 0; have = 0; prev = '0;
    for (int guard = 0; guard < 70; guard++) begin
      found = 0; best = '0;
      for (int i = 0; i < LANES; i++) begin
        if (m[i]) begin
          for (int p = 0; p < 2; p++) begin
            sg = (p == 0) ? s0[i][SA-1:2] : s1[i][SA-1:2];
            if ((!have || sg > prev) && (!found || sg < best)) begin
              best = sg; found = 1;
            end
          end
        end
      end
      if (!found) break;
      ln = '0; t = '0;
      for (int i = 0; i < LANES; i++) begin
        if (m[i] && s0[i][SA-1:2] == best) begin ln[i] = 1'b1; t[s0[i][1:0]] = 1'b1; end
        if (m[i] && s1[i][SA-1:2] == best) begin ln[i] = 1'b1; t[s1[i][1:0]] = 1'b1; end
      end
      cnt = int'(t[0]) + int'(t[1]) + int'(t[2]) + int'(t[3]);
      idx = t[1] ? 1 : t[2] ? 2 : t[3] ? 3 : 0;
      if (cnt == 1) begin
        e_size[e_n] = 2'd0; e_base[e_n] = (32'(best) << 7) + 32'(idx * 32);
      end else if (t[3:2] == 2'b00) begin
        e_size[e_n] = 2'd1; e_base[e_n] = 32'(best) << 7;
      end else if (t[1:0] == 2'b00) begin
        e_size[e_n] = 2'd1; e_base[e_n] = (32'(best) << 7) + 32'd64;
      end else begin
        e_size[e_n] = 2'd2; e_base[e_n] = 32'(best) << 7;
      end
      e_lanes[e_n] = ln;
      prev = best; have = 1; e_n++;
    end
  endfunction

  task automatic run_req(input string name);
    int k;
    bit held, done, r;
    logic [AW-1:0] hb; logic [1:0] hs; logic [LANES-1:0] hl; logic hlast;
    build_expected();
    @(negedge clk);
    chk(in_ready, {"R1 ready before ", name}, 64'(in_ready), 64'd1);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a[i];
    in_mask = m; in_esz = esz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    k = 0; held = 0; done = (e_n == 0);
    obs_base0 = '0; obs_size0 = '0; obs_lanes0 = '0;
    if (m == '0) begin
      chk(!tx_valid && in_ready, {"R10 empty request ", name}, 64'({tx_valid, in_ready}), 64'b01);
    end
    while (!done) begin
      if (held) begin
        chk(tx_valid && tx_base == hb && tx_size == hs && tx_lanes == hl && tx_last == hlast,
            {"R9 hold ", name}, 64'(tx_base), 64'(hb));
      end
      chk(!in_ready, {"R1 closed while busy ", name}, 64'(in_ready), 64'd0);
      r = ($urandom % 4) != 0;
      tx_ready = r;
      held = 0;
      if (tx_valid) begin
        if (r) begin
          if (k < e_n) begin
            chk(tx_base == e_base[k] && tx_size == e_size[k], {"R4 R5 R7 base/size ", name},
                64'({tx_size, tx_base}), 64'({e_size[k], e_base[k]}));
            chk(tx_lanes == e_lanes[k], {"R6 R2 lanes ", name}, 64'(tx_lanes), 64'(e_lanes[k]));
            chk(tx_last == (k == e_n - 1), {"R8 last ", name}, 64'(tx_last), 64'(k == e_n - 1));
          end else begin
            chk(1'b0, {"R3 extra transaction ", name}, 64'(k), 64'(e_n));
          end
          if (k == 0) begin obs_base0 = tx_base; obs_size0 = tx_size; obs_lanes0 = tx_lanes; end
          k++;
          if (tx_last || k > e_n + 1) done = 1;
        end else begin
          held = 1; hb = tx_base; hs = tx_size; hl = tx_lanes; hlast = tx_last;
        end
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    obs_n = k;
    chk(k == e_n, {"R3 transaction count ", name}, 64'(k), 64'(e_n));
    chk(in_ready && !tx_valid, {"R1 reopen after last ", name}, 64'({in_ready, tx_valid}), 64'b10);
  endtask

  task automatic clear_req();
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_4000 + 32'(i) * 32'd4096;
    m = '0; esz = 2'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !tx_valid, "R1 reset state", 64'({in_ready, tx_valid}), 64'b10);

    // R11 unit stride 4-byte
    clear_req(); esz = 2'd2; m = '1;
    for (int i = 0; i < LANES; i++) a[i] = 32'h0000_1000 + 32'(i) * 4;
    run_req("unit stride");
    chk(obs_n == 1 && obs_size0 == 2'd2 && obs_lanes0 == '1, "R11 one 128B access",
        64'({obs_size0, obs_lanes0}), 64'({2'd2, 32'hFFFF_FFFF}));

    // R4 lower half only -> 64 bytes
    m = 32'h0000_FFFF;
    run_req("lower half");
    chk(obs_n == 1 && obs_size0 == 2'd1 && obs_base0 == 32'h1000, "R4 half segment",
        64'({obs_size0, obs_base0}), 64'({2'd1, 32'h1000}));

    // R4 top quarter only -> 32 bytes
    m = 32'hFF00_0000;
    run_req("top quarter");
    chk(obs_n == 1 && obs_size0 == 2'd0 && obs_base0 == 32'h1060, "R4 quarter segment",
        64'({obs_size0, obs_base0}), 64'({2'd0, 32'h1060}));

    // R3 R4 far quarters -> one 128-byte access
    m = 32'hFF00_00FF;
    run_req("far quarters");
    chk(obs_n == 1 && obs_size0 == 2'd2, "R3 far quarters stay one access",
        64'(obs_n), 64'd1);

    // R10 empty mask
    m = '0;
    run_req("empty mask");
    chk(obs_n == 0, "R10 no transaction", 64'(obs_n), 64'd0);

    // R2 unaligned 8-byte element across a segment edge
    clear_req(); esz = 2'd3; m = 32'h0000_0004; a[2] = 32'h0000_207C;
    run_req("straddle");
    chk(obs_n == 2 && obs_lanes0 == 32'h4, "R2 straddling lane in two accesses",
        64'(obs_n), 64'd2);

    // R3 one segment per lane, R7 reversed lane order
    clear_req(); m = '1;
    for (int i = 0; i < LANES; i++) a[i] = 32'h0001_0000 + 32'(LANES - 1 - i) * 128;
    run_req("reversed scatter");
    chk(obs_n == 32 && obs_base0 == 32'h0001_0000, "R7 lowest address first",
        64'(obs_base0), 64'h0001_0000);

    // R6 inactive lanes parked elsewhere
    clear_req(); m = 32'h5555_5555;
    for (int i = 0; i < LANES; i++)
      a[i] = (i % 2 == 0) ? 32'h0000_3000 + 32'(i) * 4 : 32'h0009_0000 + 32'(i) * 256;
    run_req("masked parking");
    chk(obs_n == 1 && obs_lanes0 == 32'h5555_5555, "R6 inactive lanes unseen",
        64'(obs_lanes0), 64'h5555_5555);

    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] b;
      int mode, stride;
      mode = int'($urandom % 5);
      esz  = 2'($urandom % 4);
      b    = ($urandom & 32'h000F_FFF8);
      stride = 1 << ($urandom % 9);
      m = (($urandom % 3) == 0) ? 32'($urandom) : '1;
      for (int i = 0; i < LANES; i++) begin
        case (mode)
          0: a[i] = (b & ~32'h7F) + 32'(i) * 4;
          1: a[i] = b + 32'(i) * 32'(stride);
          2: a[i] = b + ($urandom & 32'h3FF);
          3: a[i] = b + 32'(i) * 32'(stride) + ($urandom & 32'h7);
          default: a[i] = b + ($urandom & 32'hFFFF);
        endcase
      end
      run_req("random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule